// File: doc/BRIEF.md
# Memory-Mapped Serial NOR Flash Bridge

This block lets a host processor treat a serial NOR flash as ordinary memory. Each host read or write of a 32-bit word becomes one single-lane SPI transaction to the flash. The host sees a plain word-wide port: an address, read and write strobes, write data, read data, and a wait signal that holds the host off until the flash side has finished.

A read sends the read opcode, the address, an optional run of dummy clocks, and then clocks in four data bytes, all in one chip-select frame. A write takes three or more frames. The first carries a lone write-enable byte. The second carries the write opcode, the address and four data bytes. After that the block polls a status byte with a configurable opcode, repeating until the flash reports that it is idle. Only then does the wait signal drop. The opcodes, the address length (three or four bytes) and the dummy count come from static configuration inputs. A system would normally tie the read opcode to 0x03 and the write opcode to 0x02.

The serial side runs SPI mode 0. A parameter sets the SCLK half period in core clocks. A second parameter sets the minimum time chip select stays high between frames.

Top module: `sflash_bridge`

## Requirements
- R1: After reset, spi_cs_no is 1, spi_sclk_o is 0 and host_wait_o is 0 while no strobe is present.
- R2: host_wait_o is 1 in the same cycle that host_rd_i or host_wr_i is first seen while idle. It stays 1 until the completion cycle, where it is 0 for one cycle. If the strobe is then removed, it stays 0.
- R3: A read is one chip-select frame: cfg_rd_op_i (8 bits), then the address, then dummy clocks, then 32 data clocks. All bytes go most significant bit first.
- R4: When cfg_addr4_i is 1, the address phase is 4 bytes, host_addr_i[31:24] first. When it is 0, the phase is 3 bytes, host_addr_i[23:16] first. This applies to reads and writes alike.
- R5: A read inserts exactly cfg_dummy_i (0 to 31) SCLK cycles between the address and the data. A value of 0 inserts none.
- R6: In the completion cycle of a read, host_rdata_o holds the four received bytes. The first received byte is in bits 7:0 and the last is in bits 31:24.
- R7: A write first sends a frame holding only the byte 0x06. It then sends a frame with cfg_wr_op_i, the address and four data bytes, host_wdata_i[7:0] first.
- R8: After the data frame of a write, the block repeats frames of cfg_poll_op_i plus one received byte. It stops after the first byte whose bit 0 is 0, and host_wait_o stays 1 until then. The other status bits are ignored.
- R9: SPI mode 0: SCLK is low whenever chip select is high. MOSI changes only on falling SCLK edges. MISO is sampled on rising edges.
- R10: Chip select stays high for at least CS_GAP core clocks between two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_addr_i | input | ADDR_W | Byte address of the host access |
| host_rd_i | input | 1 | Read strobe, held until wait is low |
| host_wr_i | input | 1 | Write strobe, held until wait is low |
| host_wdata_i | input | 32 | Write word |
| host_rdata_o | output | 32 | Read word, valid in the completion cycle |
| host_wait_o | output | 1 | Stalls the host while a transaction runs |
| cfg_rd_op_i | input | 8 | Read opcode |
| cfg_wr_op_i | input | 8 | Write opcode |
| cfg_poll_op_i | input | 8 | Status-poll opcode |
| cfg_addr4_i | input | 1 | 1 selects a 4-byte address, 0 a 3-byte address |
| cfg_dummy_i | input | 5 | Dummy SCLK count for reads |
| spi_sclk_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with SCK_HALF=1, CS_GAP=3 and ADDR_W=32. A one-clock half period makes the tightest MISO setup the design must handle the normal case. It also keeps a 31-cycle dummy read short enough to run alongside the other cases. A three-clock gap gives the chip-select high-time check a bound it can actually miss. The bench flash model holds a written word in a sparse memory and reports a configurable number of busy polls. Because the busy status also carries a set bit 7, a written word can be read back through both address widths, and the check shows that only status bit 0 ends polling.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int unsigned LEN_W = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_GAP, S_DONE
  } state_e;

  typedef enum logic [2:0] {
    PH_WREN, PH_OP, PH_ADDR, PH_DUMMY, PH_RDATA, PH_WDATA, PH_POLL_OP, PH_POLL_RD
  } phase_e;
endpackage

// File: rtl/sflash_shifter.sv
module sflash_shifter #(
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned LEN_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       tx_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [7:0]       rx_o
);
  localparam int unsigned DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic             active_q, sclk_q, done_q;
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] cnt_q;
  logic [7:0]       tx_q, rx_q;
  logic             tick;

  assign tick = (div_q == DIV_W'(SCK_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      cnt_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b0;
        div_q    <= '0;
        cnt_q    <= len_i;
        tx_q     <= tx_i;
      end else if (active_q) begin
        if (tick) begin
          div_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            tx_q   <= {tx_q[6:0], 1'b0};
            cnt_q  <= cnt_q - 1'b1;
            if (cnt_q == LEN_W'(1)) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[7];
  assign done_o = done_q;
  assign rx_o   = rx_q;

  // R9
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> $stable(tx_q[7]));
  // R9
  done_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !sclk_q);
  // R3
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned CS_GAP  = 2,
  parameter logic [7:0]  WREN_OP = 8'h06
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  output logic              host_wait_o,
  input  logic [7:0]        cfg_rd_op_i,
  input  logic [7:0]        cfg_wr_op_i,
  input  logic [7:0]        cfg_poll_op_i,
  input  logic              cfg_addr4_i,
  input  logic [LEN_W-1:0]  cfg_dummy_i,
  output logic              sh_start_o,
  output logic [LEN_W-1:0]  sh_len_o,
  output logic [7:0]        sh_tx_o,
  input  logic              sh_done_i,
  input  logic [7:0]        sh_rx_i,
  output logic              spi_cs_no
);
  localparam int unsigned GAP_W = $clog2(CS_GAP + 1);

  state_e            state_q;
  phase_e            phase_q;
  logic [1:0]        idx_q;
  logic              is_wr_q, fin_q, cs_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wdata_q, rdata_q;
  logic [GAP_W-1:0]  gap_q;

  logic [31:0] addr32;
  logic [1:0]  sel;
  logic [1:0]  last_addr;
  logic [7:0]  addr_byte;

  assign addr32    = 32'(addr_q);
  assign sel       = cfg_addr4_i ? idx_q : idx_q + 2'd1;
  assign last_addr = cfg_addr4_i ? 2'd3 : 2'd2;
  assign addr_byte = 8'(addr32 >> {2'(2'd3 - sel), 3'b000});

  always_comb begin
    sh_len_o = LEN_W'(8);
    sh_tx_o  = 8'h00;
    case (phase_q)
      PH_WREN:    sh_tx_o = WREN_OP;
      PH_OP:      sh_tx_o = is_wr_q ? cfg_wr_op_i : cfg_rd_op_i;
      PH_ADDR:    sh_tx_o = addr_byte;
      PH_DUMMY:   sh_len_o = cfg_dummy_i;
      PH_WDATA:   sh_tx_o = wdata_q[{idx_q, 3'b000} +: 8];
      PH_POLL_OP: sh_tx_o = cfg_poll_op_i;
      default:    ;
    endcase
  end

  assign sh_start_o = (state_q == S_ISSUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      phase_q <= PH_OP;
      idx_q   <= '0;
      is_wr_q <= 1'b0;
      fin_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      gap_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (host_rd_i || host_wr_i) begin
          is_wr_q <= host_wr_i;
          addr_q  <= host_addr_i;
          wdata_q <= host_wdata_i;
          phase_q <= host_wr_i ? PH_WREN : PH_OP;
          idx_q   <= '0;
          fin_q   <= 1'b0;
          cs_n_q  <= 1'b0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (sh_done_i) begin
          state_q <= S_ISSUE;
          case (phase_q)
            PH_WREN: begin
              phase_q <= PH_OP;
              cs_n_q  <= 1'b1; gap_q <= '0; state_q <= S_GAP;
            end
            PH_OP: begin
              phase_q <= PH_ADDR;
              idx_q   <= '0;
            end
            PH_ADDR: if (idx_q == last_addr) begin
              idx_q <= '0;
              if (is_wr_q)                 phase_q <= PH_WDATA;
              else if (cfg_dummy_i != '0)  phase_q <= PH_DUMMY;
              else                         phase_q <= PH_RDATA;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
            PH_DUMMY: phase_q <= PH_RDATA;
            PH_RDATA: begin
              rdata_q[{idx_q, 3'b000} +: 8] <= sh_rx_i;
              if (idx_q == 2'd3) begin
                fin_q  <= 1'b1;
                cs_n_q <= 1'b1; gap_q <= '0; state_q <= S_GAP;
              end else begin
                idx_q <= idx_q + 2'd1;
              end
            end
            PH_WDATA: if (idx_q == 2'd3) begin
              phase_q <= PH_POLL_OP;
              cs_n_q  <= 1'b1; gap_q <= '0; state_q <= S_GAP;
            end else begin
              idx_q <= idx_q + 2'd1;
            end
            PH_POLL_OP: phase_q <= PH_POLL_RD;
            PH_POLL_RD: begin
              phase_q <= PH_POLL_OP;
              if (!sh_rx_i[0]) fin_q <= 1'b1;  // bit 0 = busy
              cs_n_q  <= 1'b1; gap_q <= '0; state_q <= S_GAP;
            end
            default: ;
          endcase
        end
        S_GAP: if (gap_q == GAP_W'(CS_GAP - 1)) begin
          if (fin_q) begin
            state_q <= S_DONE;
          end else begin
            cs_n_q  <= 1'b0;
            state_q <= S_ISSUE;
          end
        end else begin
          gap_q <= gap_q + 1'b1;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign host_wait_o  = (state_q == S_DONE) ? 1'b0
                      : ((state_q != S_IDLE) || host_rd_i || host_wr_i);
  assign host_rdata_o = rdata_q;
  assign spi_cs_no    = cs_n_q;

  // R10
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_q) |-> ($past(state_q) == S_GAP || $past(state_q) == S_IDLE));
  // R2
  req_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && (host_rd_i || host_wr_i)) |=> (state_q == S_ISSUE));
  // R6
  rd_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DONE && !is_wr_q) |-> (idx_q == 2'd3 && cs_n_q));
  // R8
  wr_after_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DONE && is_wr_q) |-> (phase_q == PH_POLL_OP && $past(state_q) == S_GAP));
endmodule

// File: rtl/sflash_bridge.sv
module sflash_bridge #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned CS_GAP   = 2,
  parameter logic [7:0]  WREN_OP  = 8'h06
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [ADDR_W-1:0]            host_addr_i,
  input  logic                         host_rd_i,
  input  logic                         host_wr_i,
  input  logic [31:0]                  host_wdata_i,
  output logic [31:0]                  host_rdata_o,
  output logic                         host_wait_o,
  input  logic [7:0]                   cfg_rd_op_i,
  input  logic [7:0]                   cfg_wr_op_i,
  input  logic [7:0]                   cfg_poll_op_i,
  input  logic                         cfg_addr4_i,
  input  logic [sflash_pkg::LEN_W-1:0] cfg_dummy_i,
  output logic                         spi_sclk_o,
  output logic                         spi_cs_no,
  output logic                         spi_mosi_o,
  input  logic                         spi_miso_i
);
  localparam int unsigned LEN_W = sflash_pkg::LEN_W;

  logic             sh_start, sh_done;
  logic [LEN_W-1:0] sh_len;
  logic [7:0]       sh_tx, sh_rx;

  sflash_seq #(
    .ADDR_W (ADDR_W),
    .CS_GAP (CS_GAP),
    .WREN_OP(WREN_OP)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_addr_i  (host_addr_i),
    .host_rd_i    (host_rd_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .host_wait_o  (host_wait_o),
    .cfg_rd_op_i  (cfg_rd_op_i),
    .cfg_wr_op_i  (cfg_wr_op_i),
    .cfg_poll_op_i(cfg_poll_op_i),
    .cfg_addr4_i  (cfg_addr4_i),
    .cfg_dummy_i  (cfg_dummy_i),
    .sh_start_o   (sh_start),
    .sh_len_o     (sh_len),
    .sh_tx_o      (sh_tx),
    .sh_done_i    (sh_done),
    .sh_rx_i      (sh_rx),
    .spi_cs_no    (spi_cs_no)
  );

  sflash_shifter #(
    .SCK_HALF(SCK_HALF),
    .LEN_W   (LEN_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sh_start),
    .len_i  (sh_len),
    .tx_i   (sh_tx),
    .miso_i (spi_miso_i),
    .sclk_o (spi_sclk_o),
    .mosi_o (spi_mosi_o),
    .done_o (sh_done),
    .rx_o   (sh_rx)
  );

  // R9
  cs_idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sclk_o);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (spi_cs_no && !spi_sclk_o));
endmodule

// File: tb/sflash_bridge_test.sv
`timescale 1ns/1ps
module sflash_bridge_test;
  localparam int CS_GAP = 3;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic        rd = 1'b0, wr = 1'b0, wait_o;
  logic [7:0]  rd_op = 8'h03, wr_op = 8'h02, poll_op = 8'h05;
  logic        addr4 = 1'b0;
  logic [4:0]  dummy = '0;
  logic        sclk, cs_n, mosi, miso = 1'b0;

  int vec = 0, err = 0, cyc_total = 0;

  always #2.5 clk = ~clk;

  sflash_bridge #(.ADDR_W(32), .SCK_HALF(1), .CS_GAP(CS_GAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .host_addr_i(addr), .host_rd_i(rd), .host_wr_i(wr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_wait_o(wait_o),
    .cfg_rd_op_i(rd_op), .cfg_wr_op_i(wr_op), .cfg_poll_op_i(poll_op),
    .cfg_addr4_i(addr4), .cfg_dummy_i(dummy),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
  endtask

  // ---------------- flash model ----------------
  logic [7:0]   mem [int];
  logic [127:0] fq_v[$];
  int           fq_n[$];
  logic [127:0] fv;
  int           fn, hi_run = 100, busy_left = 0, busy_set = 0;
  logic [31:0]  cur_addr;
  logic         sclk_p = 1'b0, cs_p = 1'b1, mosi_p = 1'b0;

  function automatic int nab();
    return addr4 ? 4 : 3;
  endfunction
  function automatic logic [31:0] amask(logic [31:0] a);
    return addr4 ? a : (a & 32'h00FF_FFFF);
  endfunction
  function automatic logic [7:0] mem_rd(logic [31:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'((a * 13) + 32'h27);
  endfunction
  function automatic logic [7:0] get_byte(logic [127:0] v, int n, int k);
    return 8'(v >> (n - 8 - 8 * k));
  endfunction

  function automatic logic model_bit(int b);
    logic [7:0] op, by;
    int ds, j;
    if (b < 8) return 1'b0;
    op = 8'(fv >> (b - 8 + 8));
    op = get_byte(fv, b, 0);
    ds = 8 + 8 * nab() + int'(dummy);
    if (op == rd_op && b >= ds && b < ds + 32) begin
      j  = b - ds;
      by = mem_rd(cur_addr + 32'(j / 8));
      return by[7 - (j % 8)];
    end
    if (op == poll_op && b < 16) begin
      by = (busy_left > 0) ? 8'h81 : 8'h80;
      return by[7 - (b - 8)];
    end
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      err++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc_total);
      report();
      $finish;
    end
    if (rst_n) begin
      // R9: clock parked low while deselected, MOSI steady while SCLK high
      chk("R9 sclk low when cs high", (cs_n && sclk), 0);
      if (sclk && sclk_p) chk("R9 mosi stable while sclk high", mosi, mosi_p);
      if (!cs_n && cs_p) begin
        chk("R10 cs high gap", (hi_run >= CS_GAP), 1);
        fv = '0; fn = 0; miso = 1'b0;
      end
      if (cs_n && !cs_p) begin
        logic [7:0] op;
        int n;
        logic [31:0] a;
        fq_v.push_back(fv); fq_n.push_back(fn);
        n  = nab();
        op = (fn >= 8) ? get_byte(fv, fn, 0) : 8'h00;
        if (op == wr_op && fn == 8 + 8 * n + 32) begin
          a = '0;
          for (int k = 0; k < n; k++) a = (a << 8) | 32'(get_byte(fv, fn, 1 + k));
          for (int k = 0; k < 4; k++) mem[int'(a + 32'(k))] = get_byte(fv, fn, 1 + n + k);
          busy_left = busy_set;
        end else if (op == poll_op && busy_left > 0) begin
          busy_left--;
        end
      end
      if (cs_n) hi_run++; else hi_run = 0;
      if (!cs_n) begin
        if (sclk && !sclk_p) begin
          fv = {fv[126:0], mosi};
          fn++;
          if (fn == 8 + 8 * nab()) cur_addr = amask(32'(fv));
        end
        if (!sclk && sclk_p) miso = model_bit(fn);
      end
    end
    sclk_p = sclk; cs_p = cs_n; mosi_p = mosi;
  end

  // ---------------- host tasks ----------------
  task automatic wait_done(output int cyc);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!wait_o) break;
    end
  endtask

  task automatic check_addr(string req, int f, logic [31:0] a);
    for (int k = 0; k < nab(); k++)
      chk(req, get_byte(fq_v[f], fq_n[f], 1 + k), 8'(a >> (8 * (nab() - 1 - k))));
  endtask

  task automatic do_read(logic [31:0] a);
    logic [31:0] exp;
    int cyc, bits;
    a   = amask(a);
    exp = {mem_rd(a + 3), mem_rd(a + 2), mem_rd(a + 1), mem_rd(a)};
    bits = 8 + 8 * nab() + int'(dummy) + 32;
    fq_v.delete(); fq_n.delete();
    @(negedge clk);
    addr = a; rd = 1'b1;
    #0.5 chk("R2 wait rises with read strobe", wait_o, 1);
    wait_done(cyc);
    chk("R2 wait held through read frame", (cyc >= 2 * bits), 1);
    chk("R6 read data word", rdata, exp);
    rd = 1'b0;
    @(negedge clk);
    chk("R2 wait low after completion", wait_o, 0);
    chk("R3 one frame per read", fq_n.size(), 1);
    chk("R5 read frame length incl dummy", fq_n[0], bits);
    chk("R3 read opcode", get_byte(fq_v[0], fq_n[0], 0), rd_op);
    check_addr("R4 read address bytes", 0, a);
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] d, int busy);
    int cyc, n;
    a = amask(a);
    n = nab();
    busy_set = busy;
    fq_v.delete(); fq_n.delete();
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #0.5 chk("R2 wait rises with write strobe", wait_o, 1);
    wait_done(cyc);
    wr = 1'b0;
    @(negedge clk);
    chk("R2 wait low after write", wait_o, 0);
    chk("R8 frames = wren + data + polls", fq_n.size(), busy + 3);
    if (fq_n.size() == busy + 3) begin
      chk("R7 wren frame length", fq_n[0], 8);
      chk("R7 wren byte", get_byte(fq_v[0], 8, 0), 8'h06);
      chk("R7 data frame length", fq_n[1], 8 + 8 * n + 32);
      chk("R7 write opcode", get_byte(fq_v[1], fq_n[1], 0), wr_op);
      check_addr("R4 write address bytes", 1, a);
      for (int k = 0; k < 4; k++)
        chk("R7 write data byte order", get_byte(fq_v[1], fq_n[1], 1 + n + k), 8'(d >> (8 * k)));
      for (int p = 2; p < busy + 3; p++) begin
        chk("R8 poll frame length", fq_n[p], 16);
        chk("R8 poll opcode", get_byte(fq_v[p], 16, 0), poll_op);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs high in reset", cs_n, 1);
    chk("R1 sclk low in reset", sclk, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cs idle", cs_n, 1);
    chk("R1 sclk idle", sclk, 0);
    chk("R1 wait idle", wait_o, 0);

    do_read(32'h0012_3456);                     // 3-byte, no dummy
    addr4 = 1'b1; dummy = 5'd8;
    do_read(32'hA1B2_C3D4);                     // 4-byte, 8 dummy
    addr4 = 1'b0; dummy = 5'd31;
    do_read(32'h0000_0010);                     // R5 max dummy
    dummy = 5'd0;
    do_write(32'h0000_0200, 32'hDEAD_BEEF, 2);  // R8 two busy polls
    do_read(32'h0000_0200);
    chk("R6 readback of written word", rdata, 32'hDEAD_BEEF);
    addr4 = 1'b1;
    do_write(32'h0100_0300, 32'h0BAD_F00D, 0);  // R4 4-byte write, ready at once
    rd_op = 8'h0B; dummy = 5'd8;
    do_read(32'h0100_0300);
    chk("R3 alternate opcode readback", rdata, 32'h0BAD_F00D);

    repeat (5) @(negedge clk);
    report();
    $finish;
  end
endmodule